// File: doc/BRIEF.md
# Per-VC Route Computation Stage

This block is the routing-computation stage of one router input that carries several virtual channels. For every VC it keeps a registered output-port value and a route-valid flag for the packet now in that VC. When a head flit (or a single-flit packet) sits at the front of a VC buffer and that VC has no route yet, the block computes the next hop with dimension-ordered XY routing on a 2D mesh. It compares the flit's destination coordinates with the router's own coordinates: X is resolved first, then Y, and a flit that has arrived goes to the local port. The result is written into that VC's register. The register and flag clear when the packet's last flit is granted to leave the buffer.

Two build variants are selected by a parameter. In the default variant every VC has its own routing unit, so any number of VCs can be routed in the same cycle. In the shared variant a single routing unit serves all VCs. A fixed-priority arbiter picks one requesting VC per cycle, with the lowest index winning. A multiplexer steers that VC's destination into the unit. VCs that lose keep requesting until they are served.

The downstream allocators read the per-VC port and valid outputs. Both outputs are registered, so a route appears one cycle after its head flit reaches the front.

Top module: `rc_stage`

## Requirements
- R1: While reset is high and in the first cycle after it, every route-valid flag and every port value is zero.
- R2: A VC whose front holds a valid head-type flit (type code 2'b01 head or 2'b11 single-flit) while its route-valid flag is low shows route-valid high and the computed port one cycle later, if it is served in that cycle.
- R3: The port code is 1 (east) when destination X is above the router's X, and 2 (west) when it is below. When X matches, the code is 3 (north) for destination Y above the router's Y, 4 (south) for Y below, and 0 (local) when Y also matches.
- R4: A grant on a VC whose valid front flit is a tail (2'b10) or single-flit (2'b11) clears that VC's flag and port to zero one cycle later. The clear wins over a route set in the same cycle.
- R5: While a VC's route is valid, its port value stays fixed. New head flits and changed destinations at its front have no effect, and a grant on a body flit (2'b00) does not clear it.
- R6: Body or tail flits at the front of a VC without a route never set its route-valid flag.
- R7: In shared mode at most one VC gains a route per cycle.
- R8: In shared mode the lowest-index requesting VC is served first. A VC that loses keeps its request and is served in a later cycle.
- R9: In per-VC mode every requesting VC gains its route in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| front_vld | input | NUM_VC | A flit is present at the front of each VC buffer |
| front_type | input | 2*NUM_VC | Flit type per VC: 00 body, 01 head, 10 tail, 11 single-flit |
| front_dst_x | input | CW*NUM_VC | Destination X of each front flit |
| front_dst_y | input | CW*NUM_VC | Destination Y of each front flit |
| leave_grant | input | NUM_VC | The front flit of the VC is granted to leave this cycle |
| route_port | output | 3*NUM_VC | Registered output-port code per VC |
| route_vld | output | NUM_VC | Registered route-valid flag per VC |

## Verification
Two kinds of event can meet in one cycle: a route being set and a route being cleared. The bench provokes this on separate VCs, with one VC's tail leaving while another VC's head arrives. It also provokes it on a single VC, with a single-flit packet granted in the cycle it first reaches the front. In that case the clear must win and the flag must stay low. In shared mode the bench also presents heads on every VC at once and on overlapping subsets. A behavioural model checks, every clock, the order in which routes appear and that each waiting VC is eventually served.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int PORT_W = 3;

  typedef enum logic [1:0] {
    FT_BODY = 2'b00,
    FT_HEAD = 2'b01,
    FT_TAIL = 2'b10,
    FT_ONE  = 2'b11
  } flit_t;

  typedef enum logic [PORT_W-1:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4
  } port_t;

  function automatic logic starts_pkt(input logic [1:0] t);
    return t[0];
  endfunction

  function automatic logic ends_pkt(input logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/rc_xy_unit.sv
module rc_xy_unit
  import rc_pkg::*;
#(
  parameter int CW   = 3,
  parameter int MY_X = 3,
  parameter int MY_Y = 4
) (
  input  logic [CW-1:0]     dst_x,
  input  logic [CW-1:0]     dst_y,
  output logic [PORT_W-1:0] port
);
  localparam logic [CW-1:0] HX = CW'(MY_X);
  localparam logic [CW-1:0] HY = CW'(MY_Y);

  always_comb begin
    if (dst_x > HX)      port = P_EAST;
    else if (dst_x < HX) port = P_WEST;
    else if (dst_y > HY) port = P_NORTH;
    else if (dst_y < HY) port = P_SOUTH;
    else                 port = P_LOCAL;
  end
endmodule

// File: rtl/rc_prio_arb.sv
module rc_prio_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (gnt == '0)) gnt[i] = 1'b1;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R7
  AST_LOW_WINS: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0) |-> ((req & (gnt - 1'b1)) == '0)); // R8
  AST_GRANT_IF_REQ: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (gnt != '0)); // R8
endmodule

// File: rtl/rc_vc_state.sv
module rc_vc_state
  import rc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [PORT_W-1:0] set_port,
  input  logic              clr_en,
  output logic [PORT_W-1:0] port_q,
  output logic              vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      vld_q  <= 1'b0;
    end else if (clr_en) begin
      port_q <= '0;
      vld_q  <= 1'b0;
    end else if (set_en && !vld_q) begin
      port_q <= set_port;
      vld_q  <= 1'b1;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (!vld_q && port_q == '0)); // R4
  AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !clr_en) |=> (vld_q && $stable(port_q))); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> (port_q == '0)); // R1
endmodule

// File: rtl/rc_stage.sv
module rc_stage
  import rc_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int CW     = 3,
  parameter int MY_X   = 3,
  parameter int MY_Y   = 4,
  parameter bit SHARED = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_VC-1:0]        front_vld,
  input  logic [2*NUM_VC-1:0]      front_type,
  input  logic [CW*NUM_VC-1:0]     front_dst_x,
  input  logic [CW*NUM_VC-1:0]     front_dst_y,
  input  logic [NUM_VC-1:0]        leave_grant,
  output logic [PORT_W*NUM_VC-1:0] route_port,
  output logic [NUM_VC-1:0]        route_vld
);
  logic [1:0]        ftype  [NUM_VC];
  logic [CW-1:0]     dx     [NUM_VC];
  logic [CW-1:0]     dy     [NUM_VC];
  logic [PORT_W-1:0] calc   [NUM_VC];
  logic [NUM_VC-1:0] req, clr, set_en;

  genvar v;
  generate
    for (v = 0; v < NUM_VC; v++) begin : g_vc
      assign ftype[v] = front_type[2*v +: 2];
      assign dx[v]    = front_dst_x[CW*v +: CW];
      assign dy[v]    = front_dst_y[CW*v +: CW];
      assign clr[v]   = front_vld[v] && leave_grant[v] && ends_pkt(ftype[v]);
      assign req[v]   = front_vld[v] && starts_pkt(ftype[v]) && !route_vld[v] && !clr[v];

      rc_vc_state u_state (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en[v]),
        .set_port (calc[v]),
        .clr_en   (clr[v]),
        .port_q   (route_port[PORT_W*v +: PORT_W]),
        .vld_q    (route_vld[v])
      );

      AST_SET_NEEDS_HEAD: assert property (@(posedge clk) disable iff (rst)
        $rose(route_vld[v]) |-> $past(front_vld[v] && front_type[2*v])); // R6
    end

    if (SHARED) begin : g_shared
      logic [NUM_VC-1:0] gnt;
      logic [CW-1:0]     sel_x, sel_y;
      logic [PORT_W-1:0] shared_port;

      rc_prio_arb #(.N(NUM_VC)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (gnt)
      );

      always_comb begin
        sel_x = '0;
        sel_y = '0;
        for (int i = 0; i < NUM_VC; i++) begin
          if (gnt[i]) begin
            sel_x = sel_x | dx[i];
            sel_y = sel_y | dy[i];
          end
        end
      end

      rc_xy_unit #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_xy (
        .dst_x (sel_x),
        .dst_y (sel_y),
        .port  (shared_port)
      );

      assign set_en = gnt;
      for (v = 0; v < NUM_VC; v++) begin : g_fan
        assign calc[v] = shared_port;
      end

      AST_ONE_NEW_ROUTE: assert property (@(posedge clk) disable iff (rst)
        $countones(route_vld & ~$past(route_vld)) <= 1); // R7
    end else begin : g_private
      for (v = 0; v < NUM_VC; v++) begin : g_unit
        rc_xy_unit #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_xy (
          .dst_x (dx[v]),
          .dst_y (dy[v]),
          .port  (calc[v])
        );
        AST_ALL_SERVED: assert property (@(posedge clk) disable iff (rst)
          req[v] |=> route_vld[v]); // R9
      end
      assign set_en = req;
    end
  endgenerate
endmodule

// File: tb/rc_stage_test.sv
module rc_stage_test;
  localparam int NV = 4;
  localparam int CW = 3;
  localparam int MX = 3;
  localparam int MY = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NV-1:0]    f_vld = '0;
  logic [2*NV-1:0]  f_typ = '0;
  logic [CW*NV-1:0] f_dx  = '0;
  logic [CW*NV-1:0] f_dy  = '0;
  logic [NV-1:0]    f_gnt = '0;
  logic [3*NV-1:0]  p_port, s_port;
  logic [NV-1:0]    p_vld, s_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string tag  = "R1";

  int ep_vld [2][NV];
  int ep_port[2][NV];

  always #4 clk = ~clk;

  rc_stage #(.NUM_VC(NV), .CW(CW), .MY_X(MX), .MY_Y(MY), .SHARED(1'b0)) uut (
    .clk(clk), .rst(rst), .front_vld(f_vld), .front_type(f_typ),
    .front_dst_x(f_dx), .front_dst_y(f_dy), .leave_grant(f_gnt),
    .route_port(p_port), .route_vld(p_vld));

  rc_stage #(.NUM_VC(NV), .CW(CW), .MY_X(MX), .MY_Y(MY), .SHARED(1'b1)) uut_shared (
    .clk(clk), .rst(rst), .front_vld(f_vld), .front_type(f_typ),
    .front_dst_x(f_dx), .front_dst_y(f_dy), .leave_grant(f_gnt),
    .route_port(s_port), .route_vld(s_vld));

  function automatic int xy_ref(int x, int y);
    if (x > MX) return 1;
    if (x < MX) return 2;
    if (y > MY) return 3;
    if (y < MY) return 4;
    return 0;
  endfunction

  // behavioural reference, one clock per call
  always @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < 2; m++)
        for (int v = 0; v < NV; v++) begin ep_vld[m][v] = 0; ep_port[m][v] = 0; end
    end else begin
      int t, x, y;
      bit served;
      served = 0;
      for (int v = 0; v < NV; v++) begin
        bit ending, wants;
        t = int'(f_typ[2*v +: 2]);
        x = int'(f_dx[CW*v +: CW]);
        y = int'(f_dy[CW*v +: CW]);
        ending = f_vld[v] && f_gnt[v] && (t == 2 || t == 3);
        for (int m = 0; m < 2; m++) begin
          wants = f_vld[v] && (t == 1 || t == 3) && ep_vld[m][v] == 0 && !ending;
          if (ending) begin
            ep_vld[m][v] = 0; ep_port[m][v] = 0;
          end else if (wants && (m == 0 || !served)) begin
            ep_vld[m][v] = 1; ep_port[m][v] = xy_ref(x, y);
            if (m == 1) served = 1;
          end
        end
      end
    end
  end

  task automatic compare();
    for (int v = 0; v < NV; v++) begin
      n_tests++;
      if (int'(p_vld[v]) != ep_vld[0][v] || int'(p_port[3*v +: 3]) != ep_port[0][v]) begin
        n_fail++;
        $display("FAIL %s per-VC vc%0d: vld=%0d port=%0d expected vld=%0d port=%0d",
                 tag, v, p_vld[v], p_port[3*v +: 3], ep_vld[0][v], ep_port[0][v]);
      end
      n_tests++;
      if (int'(s_vld[v]) != ep_vld[1][v] || int'(s_port[3*v +: 3]) != ep_port[1][v]) begin
        n_fail++;
        $display("FAIL %s shared vc%0d: vld=%0d port=%0d expected vld=%0d port=%0d",
                 tag, v, s_vld[v], s_port[3*v +: 3], ep_vld[1][v], ep_port[1][v]);
      end
    end
  endtask

  task automatic expect_bit(string t, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", t, got, exp);
    end
  endtask

  task automatic expect_port(string t, logic [2:0] got, int exp);
    n_tests++;
    if (int'(got) != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", t, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic put(int v, bit vl, int t, int x, int y, bit g);
    f_vld[v] = vl;
    f_typ[2*v +: 2] = 2'(t);
    f_dx[CW*v +: CW] = CW'(x);
    f_dy[CW*v +: CW] = CW'(y);
    f_gnt[v] = g;
  endtask

  task automatic idle_all();
    for (int v = 0; v < NV; v++) put(v, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int dst[5][2];
    dst = '{'{6, 1}, '{0, 7}, '{3, 7}, '{3, 0}, '{3, 4}};
    // R1: reset state
    @(negedge clk); @(negedge clk);
    tag = "R1";
    expect_bit("R1 reset per-VC vld", |p_vld, 1'b0);
    expect_bit("R1 reset shared vld", |s_vld, 1'b0);
    rst = 1'b0;
    step();
    expect_port("R1 port zero after reset", p_port[2:0], 0);

    // R3: each XY direction on vc1
    tag = "R3";
    for (int k = 0; k < 5; k++) begin
      put(1, 1, 1, dst[k][0], dst[k][1], 0);
      step();
      expect_bit("R2 head sets route", p_vld[1], 1'b1);
      expect_port("R3 xy direction", p_port[5:3], (k == 4) ? 0 : k + 1);
      put(1, 1, 2, 0, 0, 1);
      step();
      expect_bit("R4 tail grant clears", p_vld[1], 1'b0);
      idle_all();
      step();
    end

    // R6: body and tail without route
    tag = "R6";
    put(2, 1, 0, 7, 7, 0); put(3, 1, 2, 0, 0, 0);
    step();
    expect_bit("R6 body no route", p_vld[2], 1'b0);
    expect_bit("R6 tail no route", s_vld[3], 1'b0);

    // R5: held route ignores new head / dest and body grant
    tag = "R5";
    put(2, 1, 1, 6, 6, 0);
    step();
    put(2, 1, 1, 0, 0, 0);
    step();
    expect_port("R5 port held on new dest", p_port[8:6], 1);
    put(2, 1, 0, 1, 1, 1);
    step();
    expect_bit("R5 body grant keeps route", p_vld[2], 1'b1);

    // R4: clear of one VC while another sets; single-flit granted at arrival
    tag = "R4";
    put(2, 1, 2, 0, 0, 1); put(0, 1, 1, 3, 0, 0);
    step();
    expect_bit("R4 tail cleared", p_vld[2], 1'b0);
    expect_bit("R2 other VC set same cycle", p_vld[0], 1'b1);
    put(0, 0, 0, 0, 0, 0); put(2, 0, 0, 0, 0, 0);
    put(3, 1, 3, 5, 4, 1);
    step();
    expect_bit("R4 clear wins over set", s_vld[3], 1'b0);
    put(3, 1, 3, 5, 4, 0);
    step();
    expect_bit("R2 single-flit sets", s_vld[3], 1'b1);
    put(3, 1, 3, 5, 4, 1);
    step();
    expect_bit("R4 single-flit grant clears", s_vld[3], 1'b0);
    put(0, 1, 2, 0, 0, 1);
    step();
    idle_all();
    step();

    // R7 R8 R9: all heads together
    tag = "R8";
    for (int v = 0; v < NV; v++) put(v, 1, 1, v, 7 - v, 0);
    step();
    expect_bit("R9 per-VC all routed", &p_vld, 1'b1);
    expect_bit("R7 shared one routed", s_vld[0] && !(|s_vld[NV-1:1]), 1'b1);
    step();
    expect_bit("R8 vc1 served second", s_vld[1] && !s_vld[2], 1'b1);
    step(); step();
    expect_bit("R8 all eventually served", &s_vld, 1'b1);
    for (int v = 0; v < NV; v++) put(v, 1, 2, 0, 0, 1);
    step();
    idle_all();
    step();

    // R2: random traffic against the model
    tag = "R2";
    for (int c = 0; c < 3000; c++) begin
      for (int v = 0; v < NV; v++)
        put(v, ($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 8),
            int'($urandom % 8), ($urandom % 3) == 0);
      step();
    end
    idle_all();
    step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule